// File: doc/BRIEF.md
# Supply-Qualified Memory Chip-Enable Gate

This block sits between a processor's active-low memory chip-enable and the memory it selects. While the supply monitor reports a healthy supply, the enable is passed through with one register stage. When the monitor raises its fault flag, the gate closes, so the memory cannot be written while the supply is collapsing.

Closing the gate without warning could cut a write cycle in half. So if an access is already under way when the fault arrives, the gate holds the enable active. It lets go when the processor ends the access or when a bounded grace window runs out, whichever comes first. The grace window is set in nanoseconds and converted to clock cycles from the clock frequency. Once the gate has closed, it stays shut until the fault flag clears. A status output tells the rest of the chip when the input is not reaching the memory.

Top module: `supply_ce_gate`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the next state has `mem_ce_n` = 1 and `gate_shut` = 1.
- R2: At an edge where `supply_fault` is sampled 0, `mem_ce_n` takes the value `cpu_ce_n` had at that edge, and `gate_shut` becomes 0. Chip-enables are active low: 0 means selected.
- R3: At an edge where `supply_fault` is sampled 1 and `cpu_ce_n` is sampled 1, `mem_ce_n` becomes 1.
- R4: If the gate is passing an active enable (`mem_ce_n` = 0) and `supply_fault` is then sampled 1 with `cpu_ce_n` still 0, `mem_ce_n` stays 0 and `gate_shut` stays 0. This grace period lasts while `cpu_ce_n` stays 0, up to the limit in R6.
- R5: During a grace period, the first edge that samples `cpu_ce_n` = 1 sets `mem_ce_n` = 1 and `gate_shut` = 1.
- R6: A grace period lasts at most GRACE_CYCLES = ceil(CLK_KHZ × GRACE_NS / 1e6) edges, which is 1750 at the defaults of 125000 kHz and 14000 ns. With `cpu_ce_n` held 0, `mem_ce_n` is 0 after edges 0 through GRACE_CYCLES−1, counted from the edge that first sampled the fault. It is 1 after edge GRACE_CYCLES.
- R7: While the gate is shut and `supply_fault` stays 1, `mem_ce_n` stays 1 and `gate_shut` stays 1, whatever `cpu_ce_n` does. An enable that first falls during a fault never reaches the memory.
- R8: Whenever `gate_shut` is 1, `mem_ce_n` is 1.
- R9: The first edge that samples `supply_fault` = 0 reopens the gate, even if `cpu_ce_n` is 0 at that edge. This holds whether the gate was shut or in a grace period. `mem_ce_n` then equals the sampled `cpu_ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the gate logic |
| supply_fault | input | 1 | 1 while the supply monitor holds the system in reset |
| cpu_ce_n | input | 1 | Active-low chip-enable from the processor |
| mem_ce_n | output | 1 | Gated active-low chip-enable to the memory |
| gate_shut | output | 1 | 1 while the processor's enable is not being passed |

## Verification
The assertions assume that `supply_fault` and `cpu_ce_n` are already synchronous to `clk` and never X once reset is released. They also assume that the grace bound is observed only through a run of cycles in which a fault and a low output are both present. The bench drives every input just after the falling clock edge and holds it for one full cycle, so each rising edge samples a clean, settled value. It only raises the fault while the output is low from a prior passed access when it is testing the grace behaviour.

// File: rtl/ceg_pkg.sv
// Package: shared types for the supply-qualified chip-enable gate.
// Assumes nothing beyond IEEE 1800-2017.
package ceg_pkg;

    // Gate operating state.
    typedef enum logic [1:0] {
        GS_PASS  = 2'd0,  // input passed to memory
        GS_GRACE = 2'd1,  // fault seen, access in flight allowed to finish
        GS_SHUT  = 2'd2   // output forced inactive
    } gate_state_e;

    // Convert a time window to clock cycles, rounding up, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned khz,
                                                 input int unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(khz) * longint'(ns);
        cyc  = (prod + 64'd999999) / 64'd1000000;
        if (cyc == 64'd0) cyc = 64'd1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/ceg_grace_timer.sv
// Module: ceg_grace_timer
// Counts clock edges spent in a grace period and flags the last permitted one.
// Assumes clear and run are never both high; clear has priority if they are.
// LIMIT must be at least 1.
module ceg_grace_timer #(
    parameter int unsigned LIMIT = 1750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the grace counter, saturating at the last permitted edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Purpose: tell the controller this edge is the last one allowed.
    always_comb begin
        expired = (cnt_q == LAST);
    end

    // The counter never leaves the permitted range of the grace window.
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // A cleared timer is at zero on the next edge.
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/ceg_gate_ctrl.sv
// Module: ceg_gate_ctrl
// State machine deciding whether the processor chip-enable reaches memory.
// Assumes supply_fault and cpu_ce_n are synchronous to clk.
// The output and the shut flag are registered together.
module ceg_gate_ctrl
    import ceg_pkg::*;
#(
    parameter int unsigned GRACE_CYCLES = 1750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_fault,
    input  logic cpu_ce_n,
    input  logic grace_expired,
    output logic grace_clear,
    output logic grace_run,
    output logic mem_ce_n,
    output logic gate_shut
);
    localparam int unsigned RUN_W = $clog2(GRACE_CYCLES + 3);

    gate_state_e state_q, state_d;
    logic        out_q, out_d;

    // Purpose: choose the next state and output value from the sampled inputs.
    always_comb begin
        state_d = state_q;
        out_d   = 1'b1;
        unique case (state_q)
            GS_PASS: begin
                if (!supply_fault) begin
                    out_d = cpu_ce_n;
                end else if (!cpu_ce_n && !out_q) begin
                    state_d = GS_GRACE;
                    out_d   = 1'b0;
                end else begin
                    state_d = GS_SHUT;
                end
            end
            GS_GRACE: begin
                if (!supply_fault) begin
                    state_d = GS_PASS;
                    out_d   = cpu_ce_n;
                end else if (cpu_ce_n || grace_expired) begin
                    state_d = GS_SHUT;
                end else begin
                    out_d = 1'b0;
                end
            end
            default: begin
                if (!supply_fault) begin
                    state_d = GS_PASS;
                    out_d   = cpu_ce_n;
                end
            end
        endcase
    end

    // Purpose: register state and gated enable; reset shuts the gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_SHUT;
            out_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    // Purpose: drive the timer controls and the block outputs.
    always_comb begin
        grace_clear = (state_q != GS_GRACE);
        grace_run   = (state_q == GS_GRACE);
        mem_ce_n    = out_q;
        gate_shut   = (state_q == GS_SHUT);
    end

    // Checker state: length of the current run of edges with fault and active output.
    logic [RUN_W-1:0] run_q;

    // Purpose: count consecutive edges seeing a fault while memory is still enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_fault || mem_ce_n) begin
            run_q <= '0;
        end else if (run_q != {RUN_W{1'b1}}) begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && gate_shut));

    assert_follow_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_fault |=> ((mem_ce_n == $past(cpu_ce_n)) && !gate_shut));

    assert_idle_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_fault && cpu_ce_n) |=> mem_ce_n);

    assert_grace_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_fault && !mem_ce_n && cpu_ce_n) |=> (mem_ce_n && gate_shut));

    assert_grace_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(GRACE_CYCLES + 1));

    assert_shut_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_fault && gate_shut) |=> (mem_ce_n && gate_shut));

    assert_shut_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_shut |-> mem_ce_n);

endmodule

// File: rtl/supply_ce_gate.sv
// Module: supply_ce_gate (top)
// Passes a processor chip-enable to memory while the supply is healthy.
// A write already in progress when a fault arrives may finish within a
// bounded grace window. Assumes synchronous inputs and a clock of CLK_KHZ.
module supply_ce_gate #(
    parameter int unsigned CLK_KHZ  = 125000,
    parameter int unsigned GRACE_NS = 14000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_fault,
    input  logic cpu_ce_n,
    output logic mem_ce_n,
    output logic gate_shut
);
    localparam int unsigned GRACE_CYCLES = ceg_pkg::ns_to_cycles(CLK_KHZ, GRACE_NS);

    logic grace_clear;
    logic grace_run;
    logic grace_expired;

    ceg_grace_timer #(
        .LIMIT(GRACE_CYCLES)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (grace_clear),
        .run     (grace_run),
        .expired (grace_expired)
    );

    ceg_gate_ctrl #(
        .GRACE_CYCLES(GRACE_CYCLES)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_fault  (supply_fault),
        .cpu_ce_n      (cpu_ce_n),
        .grace_expired (grace_expired),
        .grace_clear   (grace_clear),
        .grace_run     (grace_run),
        .mem_ce_n      (mem_ce_n),
        .gate_shut     (gate_shut)
    );

    // After a reopening edge with a low input, memory is enabled at once.
    assert_reopen_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_fault && !cpu_ce_n) |=> (!mem_ce_n && !gate_shut));

    // A fault arriving mid-access with the input still low keeps the enable on.
    assert_grace_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(supply_fault) && supply_fault && !cpu_ce_n && !mem_ce_n)
        |=> (!mem_ce_n && !gate_shut));

endmodule

// File: tb/test_supply_ce_gate.sv
module test_supply_ce_gate;

    localparam int CLK_NS = 8;                       // 125 MHz
    localparam int EXP_G  = (125000 * 14 + 999) / 1000; // 14 us at 125 MHz = 1750

    logic clk = 1'b0;
    logic rst_n, supply_fault, cpu_ce_n;
    logic mem_ce_n, gate_shut;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    supply_ce_gate i_supply_ce_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_fault (supply_fault),
        .cpu_ce_n     (cpu_ce_n),
        .mem_ce_n     (mem_ce_n),
        .gate_shut    (gate_shut)
    );

    // Vector: {rst_n, fault, cpu_ce_n, exp_mem_ce_n, exp_shut}
    localparam int NV = 14;
    localparam logic [4:0] VEC [NV] = '{
        5'b01111, // R1 reset
        5'b10110, // R2 reopen, idle
        5'b10000, // R2 pass low
        5'b10110, // R2 pass high
        5'b11111, // R3 fault while idle
        5'b11011, // R7 new access during fault blocked
        5'b10000, // R9 reopen with input low
        5'b11000, // R4 grace begins
        5'b11000, // R4 grace continues
        5'b11111, // R5 access ends, gate shuts
        5'b11011, // R7 stays shut
        5'b10110, // R9 reopen idle
        5'b00011, // R1 reset mid-run
        5'b10000  // R2 pass low after reset
    };
    localparam string VTAG [NV] = '{"R1","R9","R2","R2","R3","R7","R9",
                                    "R4","R4","R5","R7","R9","R1","R2"};

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic ao, input logic as_,
                         input logic eo, input logic es);
        checks++;
        if (ao !== eo || as_ !== es) begin
            failures++;
            $display("FAIL %s: mem_ce_n=%b gate_shut=%b expected %b %b",
                     tag, ao, as_, eo, es);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; supply_fault = 1'b1; cpu_ce_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            rst_n        = VEC[i][4];
            supply_fault = VEC[i][3];
            cpu_ce_n     = VEC[i][2];
            tick();
            check(VTAG[i], mem_ce_n, gate_shut, VEC[i][1], VEC[i][0]);
        end

        // R6: grace timeout with the input held low.
        rst_n = 1'b1; supply_fault = 1'b0; cpu_ce_n = 1'b0;
        tick();
        supply_fault = 1'b1;
        tick();                                   // edge 0 sampled the fault
        check("R4", mem_ce_n, gate_shut, 1'b0, 1'b0);
        for (int k = 1; k <= EXP_G; k++) begin
            tick();
            if (k == EXP_G - 1) check("R6", mem_ce_n, gate_shut, 1'b0, 1'b0);
            if (k == EXP_G)     check("R6", mem_ce_n, gate_shut, 1'b1, 1'b1);
        end

        // R7 / R8: shut state holds under input toggling.
        cpu_ce_n = 1'b1; tick();
        cpu_ce_n = 1'b0; tick();
        tick();
        check("R7", mem_ce_n, gate_shut, 1'b1, 1'b1);
        check("R8", mem_ce_n, 1'b1, 1'b1, 1'b1);

        // R9: fault clears in the middle of a grace period.
        supply_fault = 1'b0; cpu_ce_n = 1'b0; tick();
        supply_fault = 1'b1; tick();
        tick();
        check("R4", mem_ce_n, gate_shut, 1'b0, 1'b0);
        supply_fault = 1'b0; tick();
        check("R9", mem_ce_n, gate_shut, 1'b0, 1'b0);
        // Timer restarts: a fresh grace lasts the full window again.
        supply_fault = 1'b1; tick();
        for (int k = 1; k < EXP_G; k++) tick();
        check("R6", mem_ce_n, gate_shut, 1'b0, 1'b0);
        tick();
        check("R6", mem_ce_n, gate_shut, 1'b1, 1'b1);

        // R3: fault rises while input goes high on the same edge as a low output.
        supply_fault = 1'b0; cpu_ce_n = 1'b0; tick();
        supply_fault = 1'b1; cpu_ce_n = 1'b1; tick();
        check("R3", mem_ce_n, gate_shut, 1'b1, 1'b1);

        finish_run();
    end

    initial begin
        #(CLK_NS * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

endmodule